// File: doc/BRIEF.md
# Wavefront Outstanding-Access Wait Counter

This block keeps, for one wavefront, a running count of memory and export operations that have been issued but have not yet completed, split into three classes: vector memory, export, and a combined class for local shared memory, scalar memory and messages. An issue port tells it which kind of operation left the wavefront, and one completion strobe per class reports operations that finished. Decoding that issue port is how the block decides which counter moves.

When the scalar pipe delivers a wait command, it carries one threshold per class. The block stalls the wavefront until, for every class whose threshold is not the all-ones "ignore" value, the outstanding count is no larger than the threshold. It then drops the stall and disarms the thresholds. A wait command tagged as vector, or a completion reported on a class whose count is already zero, raises a sticky error flag.

Top module: `wf_waitcnt_tracker`

## Requirements
- R1: After synchronous active-low reset, `stalled` and `err` are 0, every count is zero and every threshold is disarmed, so a wait command with all thresholds 0 does not leave the wavefront stalled.
- R2: The vector-memory count rises by one on issue code 1 (global), and on issue code 3 (flat) with segment code 0 (global) or 1 (private). Flat with segment 2 (group), and all other codes, leave it unchanged.
- R3: The shared count rises by one on issue code 2 (local), 5 (scalar memory), 6 (message), and on code 3 (flat) with segment 2 (group). The export count rises by one on code 4 (export). Code 0 issues nothing.
- R4: Threshold widths are 4 bits (vector memory), 3 bits (export) and 5 bits (shared). While a wait is active and an armed class has a count above its threshold, `stalled` stays 1.
- R5: A threshold equal to its field's all-ones value (15, 7, 31) disarms that class, whatever its count.
- R6: In the first cycle in which every armed class is satisfied, the stall is removed at the next clock edge and all thresholds return to all-ones, so later issues do not re-stall the wavefront.
- R7: A wait command with `wait_is_vector` = 1 sets `err` in the next cycle and does not stall the wavefront.
- R8: A completion on a class whose count is zero, with no issue of that class in the same cycle, sets `err` (sticky until reset) and the count stays at zero.
- R9: An issue and a completion of the same class in the same cycle leave that count unchanged.
- R10: A wait command that arrives while the wavefront is already stalled is ignored.
- R11: An accepted wait command sets `stalled` at the next clock edge, even if its conditions are already met; the release follows one edge later.
- R12: A count already at its maximum (63 with 6-bit counters) stays there on a further issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_op | input | 3 | Issued operation code (0 none, 1 global, 2 local, 3 flat, 4 export, 5 scalar memory, 6 message) |
| iss_seg | input | 2 | Segment a flat operation resolved to (0 global, 1 private, 2 group) |
| done_vmem | input | 1 | One vector-memory operation completed |
| done_exp | input | 1 | One export completed |
| done_shr | input | 1 | One shared-class operation completed |
| wait_valid | input | 1 | Wait command present this cycle |
| wait_is_vector | input | 1 | The wait command came from a vector instruction (illegal) |
| wait_vmem_thr | input | 4 | Vector-memory threshold, 15 disarms |
| wait_exp_thr | input | 3 | Export threshold, 7 disarms |
| wait_shr_thr | input | 5 | Shared-class threshold, 31 disarms |
| stalled | output | 1 | Wavefront held by a wait command |
| err | output | 1 | Sticky error: vector wait command or completion on an empty count |

## Verification
A table sends a single operation of each issue and segment code from reset, then probes with a wait armed on one class, so each stall result shows which counter moved and that the others did not. Thresholds are set one below, equal to and at the disarming value against the count, which separates a strict from a non-strict compare and an armed from a disarmed field. Directed sequences cover the exact release edge, a second wait during a stall, issue and completion together, completion on an empty count, and saturation at the counter's maximum. In each case the result at the ports differs between a correct design and one that wraps or releases early.

// File: rtl/wfw_pkg.sv
// Shared codes for the wavefront wait counter.
// Assumes: issue codes and segment codes are driven by the issue stage as listed.
package wfw_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_GLOBAL = 3'd1,
        OP_LOCAL  = 3'd2,
        OP_FLAT   = 3'd3,
        OP_EXPORT = 3'd4,
        OP_SMEM   = 3'd5,
        OP_MSG    = 3'd6
    } wfw_op_e;

    typedef enum logic [1:0] {
        SEG_GLOBAL  = 2'd0,
        SEG_PRIVATE = 2'd1,
        SEG_GROUP   = 2'd2,
        SEG_RSVD    = 2'd3
    } wfw_seg_e;

    localparam int NUM_CLASS = 3;
    localparam int CLS_VMEM  = 0;
    localparam int CLS_EXP   = 1;
    localparam int CLS_SHR   = 2;

endpackage

// File: rtl/wfw_issue_decode.sv
// Maps an issued operation to the counter class it occupies.
// Assumes: at most one operation is issued per cycle; unknown codes count nowhere.
module wfw_issue_decode
    import wfw_pkg::*;
(
    input  logic [2:0]           iss_op,
    input  logic [1:0]           iss_seg,
    output logic [NUM_CLASS-1:0] inc_o
);

    // Select the class bit from the operation code and flat segment.
    always_comb begin
        inc_o = '0;
        case (iss_op)
            OP_GLOBAL: inc_o[CLS_VMEM] = 1'b1;
            OP_LOCAL,
            OP_SMEM,
            OP_MSG:    inc_o[CLS_SHR]  = 1'b1;
            OP_EXPORT: inc_o[CLS_EXP]  = 1'b1;
            OP_FLAT: begin
                if (iss_seg == SEG_GLOBAL || iss_seg == SEG_PRIVATE)
                    inc_o[CLS_VMEM] = 1'b1;
                else if (iss_seg == SEG_GROUP)
                    inc_o[CLS_SHR] = 1'b1;
            end
            default: inc_o = '0;
        endcase
    end

endmodule

// File: rtl/wfw_class_slice.sv
// One class: outstanding count plus armed threshold and its satisfied test.
// Assumes: CNT_W >= THR_W; load and clear are never requested together.
module wfw_class_slice #(
    parameter int THR_W = 4,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             thr_load,
    input  logic             thr_clear,
    input  logic [THR_W-1:0] thr_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             met_o,
    output logic             underflow_o
);

    localparam logic [THR_W-1:0] THR_OFF = '1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [THR_W-1:0] thr;

    // Count issued-but-incomplete operations, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0)      cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Hold the threshold of the active wait, disarmed when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr <= THR_OFF;
        else if (thr_load)
            thr <= thr_in;
        else if (thr_clear)
            thr <= THR_OFF;
    end

    // Satisfied when disarmed or when the count is within the threshold.
    always_comb begin
        met_o = (thr == THR_OFF) || (cnt <= CNT_W'(thr));
    end

    assign underflow_o = dec && !inc && (cnt == '0);
    assign cnt_o       = cnt;

endmodule

// File: rtl/wfw_wait_ctrl.sv
// Wait-command acceptance, stall state and sticky error flag.
// Assumes: all_met reflects the thresholds loaded by the last accepted command.
module wfw_wait_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_valid,
    input  logic wait_is_vector,
    input  logic all_met,
    input  logic underflow_any,
    output logic load_o,
    output logic clear_o,
    output logic stalled_o,
    output logic err_o
);

    logic active;

    assign load_o  = wait_valid && !wait_is_vector && !active;
    assign clear_o = active && all_met;

    // Enter the stall on an accepted command, leave it once all classes are met.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (load_o)
            active <= 1'b1;
        else if (clear_o)
            active <= 1'b0;
    end

    // Latch any illegal wait source or counter underflow until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (underflow_any || (wait_valid && wait_is_vector))
            err_o <= 1'b1;
    end

    assign stalled_o = active;

endmodule

// File: rtl/wf_waitcnt_tracker.sv
// Top: three outstanding-operation classes gated by a wait command.
// Assumes: one issue per cycle; completion strobes are one per class per cycle.
module wf_waitcnt_tracker
    import wfw_pkg::*;
#(
    parameter int VMEM_THR_W = 4,
    parameter int EXP_THR_W  = 3,
    parameter int SHR_THR_W  = 5,
    parameter int CNT_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            iss_op,
    input  logic [1:0]            iss_seg,
    input  logic                  done_vmem,
    input  logic                  done_exp,
    input  logic                  done_shr,
    input  logic                  wait_valid,
    input  logic                  wait_is_vector,
    input  logic [VMEM_THR_W-1:0] wait_vmem_thr,
    input  logic [EXP_THR_W-1:0]  wait_exp_thr,
    input  logic [SHR_THR_W-1:0]  wait_shr_thr,
    output logic                  stalled,
    output logic                  err
);

    localparam int THR_TOTAL = VMEM_THR_W + EXP_THR_W + SHR_THR_W;

    logic [NUM_CLASS-1:0] inc_bus;
    logic [NUM_CLASS-1:0] dec_bus;
    logic [NUM_CLASS-1:0] met_bus;
    logic [NUM_CLASS-1:0] uf_bus;
    logic [THR_TOTAL-1:0] thr_flat;
    logic [CNT_W-1:0]     cnt_bus [NUM_CLASS];
    logic                 thr_load;
    logic                 thr_clear;
    logic                 all_met;

    assign dec_bus  = {done_shr, done_exp, done_vmem};
    assign thr_flat = {wait_shr_thr, wait_exp_thr, wait_vmem_thr};
    assign all_met  = &met_bus;

    wfw_issue_decode u_dec (
        .iss_op  (iss_op),
        .iss_seg (iss_seg),
        .inc_o   (inc_bus)
    );

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cls
        localparam int TW  = (g == CLS_VMEM) ? VMEM_THR_W :
                             (g == CLS_EXP)  ? EXP_THR_W  : SHR_THR_W;
        localparam int OFF = (g == CLS_VMEM) ? 0 :
                             (g == CLS_EXP)  ? VMEM_THR_W : VMEM_THR_W + EXP_THR_W;
        wfw_class_slice #(
            .THR_W (TW),
            .CNT_W (CNT_W)
        ) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .inc         (inc_bus[g]),
            .dec         (dec_bus[g]),
            .thr_load    (thr_load),
            .thr_clear   (thr_clear),
            .thr_in      (thr_flat[OFF +: TW]),
            .cnt_o       (cnt_bus[g]),
            .met_o       (met_bus[g]),
            .underflow_o (uf_bus[g])
        );
    end

    wfw_wait_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wait_valid     (wait_valid),
        .wait_is_vector (wait_is_vector),
        .all_met        (all_met),
        .underflow_any  (|uf_bus),
        .load_o         (thr_load),
        .clear_o        (thr_clear),
        .stalled_o      (stalled),
        .err_o          (err)
    );

endmodule

// File: rtl/wf_waitcnt_tracker_chk.sv
// Property checker for the wait counter, attached by bind below.
// Assumes: observes the vector-memory class as representative of all slices.
module wf_waitcnt_tracker_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wait_valid,
    input logic             wait_is_vector,
    input logic             stalled,
    input logic             err,
    input logic             all_met,
    input logic             inc_vmem,
    input logic             done_vmem,
    input logic [CNT_W-1:0] cnt_vmem
);

    a_r7_vector_wait_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_valid && wait_is_vector) |=> err);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r8_no_negative: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_vmem == '0 && done_vmem && !inc_vmem) |=> (cnt_vmem == '0 && err));

    a_r9_same_cycle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_vmem && done_vmem) |=> $stable(cnt_vmem));

    a_r11_accept_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_valid && !wait_is_vector && !stalled) |=> stalled);

    a_r6_release_next: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && all_met) |=> !stalled);

    a_r4_hold_unmet: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !all_met) |=> stalled);

endmodule

bind wf_waitcnt_tracker wf_waitcnt_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wait_valid     (wait_valid),
    .wait_is_vector (wait_is_vector),
    .stalled        (stalled),
    .err            (err),
    .all_met        (all_met),
    .inc_vmem       (inc_bus[0]),
    .done_vmem      (done_vmem),
    .cnt_vmem       (cnt_bus[0])
);

// File: tb/test_wf_waitcnt_tracker.sv
// Self-checking bench: table of single-issue probes, then directed cases.
module test_wf_waitcnt_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] iss_op = '0;
    logic [1:0] iss_seg = '0;
    logic       done_vmem = 1'b0;
    logic       done_exp = 1'b0;
    logic       done_shr = 1'b0;
    logic       wait_valid = 1'b0;
    logic       wait_is_vector = 1'b0;
    logic [3:0] wait_vmem_thr = '1;
    logic [2:0] wait_exp_thr = '1;
    logic [4:0] wait_shr_thr = '1;
    logic       stalled;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    wf_waitcnt_tracker i_wf_waitcnt_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .iss_op         (iss_op),
        .iss_seg        (iss_seg),
        .done_vmem      (done_vmem),
        .done_exp       (done_exp),
        .done_shr       (done_shr),
        .wait_valid     (wait_valid),
        .wait_is_vector (wait_is_vector),
        .wait_vmem_thr  (wait_vmem_thr),
        .wait_exp_thr   (wait_exp_thr),
        .wait_shr_thr   (wait_shr_thr),
        .stalled        (stalled),
        .err            (err)
    );

    // Row: op, seg, vmem thr, exp thr, shr thr, expected stall after probe.
    localparam int NROW = 15;
    localparam logic [17:0] TBL [NROW] = '{
        {3'd1, 2'd0, 4'd0,  3'd7, 5'd31, 1'b1},  // R2 global
        {3'd3, 2'd0, 4'd0,  3'd7, 5'd31, 1'b1},  // R2 flat global
        {3'd3, 2'd1, 4'd0,  3'd7, 5'd31, 1'b1},  // R2 flat private
        {3'd3, 2'd2, 4'd0,  3'd7, 5'd31, 1'b0},  // R2 flat group not vmem
        {3'd3, 2'd2, 4'd15, 3'd7, 5'd0,  1'b1},  // R3 flat group
        {3'd2, 2'd0, 4'd15, 3'd7, 5'd0,  1'b1},  // R3 local
        {3'd2, 2'd0, 4'd0,  3'd7, 5'd31, 1'b0},  // R2 local not vmem
        {3'd4, 2'd0, 4'd15, 3'd0, 5'd31, 1'b1},  // R3 export
        {3'd4, 2'd0, 4'd0,  3'd7, 5'd0,  1'b0},  // R3 export only
        {3'd5, 2'd0, 4'd15, 3'd7, 5'd0,  1'b1},  // R3 scalar memory
        {3'd6, 2'd0, 4'd15, 3'd7, 5'd0,  1'b1},  // R3 message
        {3'd1, 2'd0, 4'd1,  3'd7, 5'd31, 1'b0},  // R4 equal not stalled
        {3'd1, 2'd0, 4'd15, 3'd7, 5'd31, 1'b0},  // R5 disarmed
        {3'd0, 2'd0, 4'd0,  3'd0, 5'd0,  1'b0},  // R3 none
        {3'd4, 2'd0, 4'd15, 3'd7, 5'd31, 1'b0}   // R5 export disarmed
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        iss_op = '0; iss_seg = '0;
        done_vmem = 1'b0; done_exp = 1'b0; done_shr = 1'b0;
        wait_valid = 1'b0; wait_is_vector = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] seg, input int n);
        for (int k = 0; k < n; k++) begin
            iss_op = op; iss_seg = seg;
            tick();
        end
        iss_op = '0; iss_seg = '0;
    endtask

    task automatic pulse_done(input int cls, input int n);
        for (int k = 0; k < n; k++) begin
            done_vmem = (cls == 0); done_exp = (cls == 1); done_shr = (cls == 2);
            tick();
        end
        done_vmem = 1'b0; done_exp = 1'b0; done_shr = 1'b0;
    endtask

    // Send an accepted wait, check R11, return stall one edge later.
    task automatic probe(input logic [3:0] vt, input logic [2:0] et,
                         input logic [4:0] st, output logic res);
        wait_valid = 1'b1; wait_is_vector = 1'b0;
        wait_vmem_thr = vt; wait_exp_thr = et; wait_shr_thr = st;
        tick();
        wait_valid = 1'b0;
        check("R11 stall after accepted wait", int'(stalled), 1);
        tick();
        res = stalled;
    endtask

    initial begin
        logic s;
        do_reset();
        check("R1 stalled after reset", int'(stalled), 0);
        check("R1 err after reset", int'(err), 0);
        probe(4'd0, 3'd0, 5'd0, s);
        check("R1 counts zero", int'(s), 0);

        // Table walk: one issue from reset, then a probe.
        for (int i = 0; i < NROW; i++) begin
            do_reset();
            issue(TBL[i][17:15], TBL[i][14:13], 1);
            probe(TBL[i][12:9], TBL[i][8:6], TBL[i][5:1], s);
            check($sformatf("R2/R3 table row %0d", i), int'(s), int'(TBL[i][0]));
        end

        // R6: exact release edge and disarm afterwards.
        do_reset();
        issue(3'd1, 2'd0, 2);
        probe(4'd1, 3'd7, 5'd31, s);
        check("R4 count 2 above thr 1", int'(s), 1);
        pulse_done(0, 1);
        check("R6 no early release", int'(stalled), 1);
        tick();
        check("R6 released next cycle", int'(stalled), 0);
        issue(3'd1, 2'd0, 3);
        check("R6 thresholds disarmed", int'(stalled), 0);

        // R10: second wait during a stall is ignored.
        probe(4'd0, 3'd7, 5'd31, s);
        check("R4 count 4 above thr 0", int'(s), 1);
        wait_valid = 1'b1; wait_vmem_thr = 4'd15; wait_exp_thr = 3'd7; wait_shr_thr = 5'd31;
        tick();
        wait_valid = 1'b0;
        tick();
        check("R10 new wait ignored", int'(stalled), 1);
        pulse_done(0, 4);
        check("R10 still held at last completion", int'(stalled), 1);
        tick();
        check("R10 released after drain", int'(stalled), 0);
        check("R8 no spurious err", int'(err), 0);

        // R7: vector-tagged wait.
        do_reset();
        issue(3'd1, 2'd0, 1);
        wait_valid = 1'b1; wait_is_vector = 1'b1; wait_vmem_thr = 4'd0;
        tick();
        wait_valid = 1'b0; wait_is_vector = 1'b0;
        check("R7 err set", int'(err), 1);
        check("R7 no stall", int'(stalled), 0);
        tick();
        check("R7 still no stall", int'(stalled), 0);

        // R8: completion on empty count.
        do_reset();
        pulse_done(1, 1);
        check("R8 err on underflow", int'(err), 1);
        issue(3'd4, 2'd0, 1);
        probe(4'd15, 3'd0, 5'd31, s);
        check("R8 count stayed zero", int'(s), 1);
        check("R8 err sticky", int'(err), 1);

        // R9: issue and completion together.
        do_reset();
        issue(3'd1, 2'd0, 1);
        iss_op = 3'd1; done_vmem = 1'b1;
        tick();
        iss_op = '0; done_vmem = 1'b0;
        probe(4'd1, 3'd7, 5'd31, s);
        check("R9 count not raised", int'(s), 0);
        probe(4'd0, 3'd7, 5'd31, s);
        check("R9 count not lowered", int'(s), 1);

        // R12: saturation at maximum count.
        do_reset();
        issue(3'd1, 2'd0, 64);
        pulse_done(0, 62);
        probe(4'd0, 3'd7, 5'd31, s);
        check("R12 one left after 62 completions", int'(s), 1);
        pulse_done(0, 1);
        tick();
        check("R12 released at zero", int'(stalled), 0);
        check("R12 no underflow", int'(err), 0);

        // R4 field widths and R5 disarm against large counts.
        do_reset();
        issue(3'd1, 2'd0, 15);
        probe(4'd14, 3'd7, 5'd31, s);
        check("R4 vmem 15 above 14", int'(s), 1);
        do_reset();
        issue(3'd4, 2'd0, 7);
        probe(4'd15, 3'd6, 5'd31, s);
        check("R4 export 7 above 6", int'(s), 1);
        do_reset();
        issue(3'd2, 2'd0, 31);
        probe(4'd15, 3'd7, 5'd30, s);
        check("R4 shared 31 above 30", int'(s), 1);
        do_reset();
        issue(3'd2, 2'd0, 32);
        issue(3'd1, 2'd0, 16);
        probe(4'd15, 3'd7, 5'd31, s);
        check("R5 all-ones ignores counts", int'(s), 0);

        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule